// File: doc/BRIEF.md
# Coherence Miss Classifier

This block sits beside the access stream of a small shared-memory multiprocessor model and labels each access. An access gives a processor id, a read or write flag, a block index and a word offset. The block keeps its own simplified invalidate-protocol state for every processor and block. It labels the access as a hit, a compulsory miss, a true-sharing miss or a false-sharing miss. It also keeps one saturating counter per label.

Classification works per word. For each processor and block, the block records which words other processors have written since that processor lost its copy or its write permission. It also records which words each processor has used since it last gained its current permission. A coherence miss counts as true sharing only when a word that was actually communicated is the word now accessed. Every other coherence miss is false sharing.

Top module: `cmc_classifier`

## Requirements
- R1: After reset all four counters read zero, `cls_valid` is low, and every line of every processor is invalid and untouched.
- R2: An access presented with `acc_valid` high produces `cls_valid` high with its code exactly one clock later. A cycle with `acc_valid` low produces `cls_valid` low one clock later.
- R3: A read finds a hit when the processor holds the block shared or exclusive. A write finds a hit only when the processor holds the block exclusive. A hit is coded 2'b00.
- R4: A miss on a block the processor has never accessed is coded 2'b01 (compulsory), whatever the other processors hold.
- R5: A miss on a previously accessed block is coded 2'b10 (true sharing) when another processor has written the accessed word since this processor lost its copy or its write permission.
- R6: A write miss is also coded 2'b10 when another processor holding a valid copy has used the same word since it gained that copy.
- R7: Any other miss on a previously accessed block is coded 2'b11 (false sharing).
- R8: A write leaves the writer exclusive and invalidates every other copy. A read miss leaves the reader shared and demotes an exclusive holder to shared.
- R9: Four 16-bit counters, one per code, each advance by one on every access with that code and hold at 16'hFFFF.
- R10: No block is ever held exclusive by more than one processor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_pid | input | $clog2(NPROC) | Processor issuing the access |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_blk | input | $clog2(NBLK) | Block index |
| acc_word | input | $clog2(NWORD) | Word offset inside the block |
| cls_valid | output | 1 | Classification below is valid |
| cls_code | output | 2 | 00 hit, 01 compulsory, 10 true sharing, 11 false sharing |
| cnt_hit | output | CW | Saturating count of hits |
| cnt_comp | output | CW | Saturating count of compulsory misses |
| cnt_true | output | CW | Saturating count of true-sharing misses |
| cnt_false | output | CW | Saturating count of false-sharing misses |

## Verification
The assertions check, on every cycle, that the result appears one clock after its access and never without one. They also check that a counter moves only alongside a result carrying its code, and that the addressed block never has two exclusive holders. Whether a particular miss is true or false sharing depends on the history of remote writes and word use. Only the bench's directed sequences can show this: the five-step two-word sharing pattern, the upgrade and demotion pattern, and the saturation run, each compared against codes and counts worked out by hand.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
  localparam logic [1:0] ST_INV = 2'd0;
  localparam logic [1:0] ST_SHR = 2'd1;
  localparam logic [1:0] ST_EXC = 2'd2;

  localparam logic [1:0] CODE_HIT   = 2'b00;
  localparam logic [1:0] CODE_COMP  = 2'b01;
  localparam logic [1:0] CODE_TRUE  = 2'b10;
  localparam logic [1:0] CODE_FALSE = 2'b11;

  // permission check for one access against the issuer's own line state
  function automatic logic access_hits(input logic [1:0] st, input logic wr);
    return wr ? (st == ST_EXC) : (st != ST_INV);
  endfunction

  // label selection; priority: hit, first touch, communicated word, else false
  function automatic logic [1:0] pick_code(input logic hit, input logic touched,
                                           input logic remote_wr, input logic peer_use,
                                           input logic wr);
    if (hit)                          return CODE_HIT;
    else if (!touched)                return CODE_COMP;
    else if (remote_wr || (wr && peer_use)) return CODE_TRUE;
    else                              return CODE_FALSE;
  endfunction

  function automatic logic [15:0] sat_step(input logic [15:0] v);
    return (v == 16'hFFFF) ? v : v + 16'd1;
  endfunction
endpackage

// File: rtl/cmc_tracker.sv
module cmc_tracker
  import cmc_pkg::*;
#(
  parameter int NPROC = 2,
  parameter int NBLK  = 4,
  parameter int NWORD = 4,
  localparam int PW = $clog2(NPROC),
  localparam int BW = $clog2(NBLK),
  localparam int WW = $clog2(NWORD)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          acc_valid,
  input  logic [PW-1:0]                 acc_pid,
  input  logic                          acc_write,
  input  logic [BW-1:0]                 acc_blk,
  input  logic [WW-1:0]                 acc_word,
  output logic [NPROC-1:0][1:0]         cur_st,
  output logic [NPROC-1:0]              cur_touch,
  output logic [NPROC-1:0][NWORD-1:0]   cur_rmask,
  output logic [NPROC-1:0][NWORD-1:0]   cur_used
);
  logic [1:0]       st_q    [NPROC][NBLK];
  logic             touch_q [NPROC][NBLK];
  logic [NWORD-1:0] rmask_q [NPROC][NBLK];
  logic [NWORD-1:0] used_q  [NPROC][NBLK];

  logic [NWORD-1:0] wbit;
  assign wbit = NWORD'(1) << acc_word;

  always_comb begin
    for (int q = 0; q < NPROC; q++) begin
      cur_st[q]    = st_q[q][acc_blk];
      cur_touch[q] = touch_q[q][acc_blk];
      cur_rmask[q] = rmask_q[q][acc_blk];
      cur_used[q]  = used_q[q][acc_blk];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int q = 0; q < NPROC; q++)
        for (int b = 0; b < NBLK; b++) begin
          st_q[q][b]    <= ST_INV;
          touch_q[q][b] <= 1'b0;
          rmask_q[q][b] <= '0;
          used_q[q][b]  <= '0;
        end
    end else if (acc_valid) begin
      for (int q = 0; q < NPROC; q++) begin
        if (PW'(q) == acc_pid) begin
          touch_q[q][acc_blk] <= 1'b1;
          if (access_hits(st_q[q][acc_blk], acc_write)) begin
            used_q[q][acc_blk] <= used_q[q][acc_blk] | wbit;
          end else begin
            // permission regained: restart both word histories
            rmask_q[q][acc_blk] <= '0;
            used_q[q][acc_blk]  <= wbit;
            st_q[q][acc_blk]    <= acc_write ? ST_EXC : ST_SHR;
          end
        end else if (acc_write) begin
          if (st_q[q][acc_blk] != ST_INV) begin
            st_q[q][acc_blk]    <= ST_INV;
            rmask_q[q][acc_blk] <= wbit;
          end else begin
            rmask_q[q][acc_blk] <= rmask_q[q][acc_blk] | wbit;
          end
        end else if (st_q[q][acc_blk] == ST_EXC) begin
          st_q[q][acc_blk]    <= ST_SHR;
          rmask_q[q][acc_blk] <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/cmc_counters.sv
module cmc_counters
  import cmc_pkg::*;
#(
  parameter int NCLS = 4,
  parameter int CW   = 16,
  localparam int KW  = $clog2(NCLS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bump,
  input  logic [KW-1:0]            code,
  output logic [NCLS-1:0][CW-1:0]  counts
);
  for (genvar k = 0; k < NCLS; k++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n)
        counts[k] <= '0;
      else if (bump && code == KW'(k))
        counts[k] <= CW'(sat_step(16'(counts[k])));
    end
  end
endmodule

// File: rtl/cmc_classifier.sv
module cmc_classifier
  import cmc_pkg::*;
#(
  parameter int NPROC = 2,
  parameter int NBLK  = 4,
  parameter int NWORD = 4,
  parameter int CW    = 16,
  localparam int PW = $clog2(NPROC),
  localparam int BW = $clog2(NBLK),
  localparam int WW = $clog2(NWORD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic [PW-1:0] acc_pid,
  input  logic          acc_write,
  input  logic [BW-1:0] acc_blk,
  input  logic [WW-1:0] acc_word,
  output logic          cls_valid,
  output logic [1:0]    cls_code,
  output logic [CW-1:0] cnt_hit,
  output logic [CW-1:0] cnt_comp,
  output logic [CW-1:0] cnt_true,
  output logic [CW-1:0] cnt_false
);
  logic [NPROC-1:0][1:0]       cur_st;
  logic [NPROC-1:0]            cur_touch;
  logic [NPROC-1:0][NWORD-1:0] cur_rmask;
  logic [NPROC-1:0][NWORD-1:0] cur_used;
  logic [3:0][CW-1:0]          counts;

  cmc_tracker #(.NPROC(NPROC), .NBLK(NBLK), .NWORD(NWORD)) u_trk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_pid(acc_pid),
    .acc_write(acc_write), .acc_blk(acc_blk), .acc_word(acc_word),
    .cur_st(cur_st), .cur_touch(cur_touch), .cur_rmask(cur_rmask), .cur_used(cur_used)
  );

  // named internal events
  logic       self_hit, self_touched, remote_wr_word, peer_used_word;
  logic [1:0] next_code;

  always_comb begin
    peer_used_word = 1'b0;
    for (int q = 0; q < NPROC; q++)
      if (PW'(q) != acc_pid && cur_st[q] != ST_INV && cur_used[q][acc_word])
        peer_used_word = 1'b1;
  end

  assign self_hit       = access_hits(cur_st[acc_pid], acc_write);
  assign self_touched   = cur_touch[acc_pid];
  assign remote_wr_word = cur_rmask[acc_pid][acc_word];
  assign next_code      = pick_code(self_hit, self_touched, remote_wr_word,
                                    peer_used_word, acc_write);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cls_valid <= 1'b0;
      cls_code  <= CODE_HIT;
    end else begin
      cls_valid <= acc_valid;
      if (acc_valid) cls_code <= next_code;
    end
  end

  cmc_counters #(.NCLS(4), .CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .bump(acc_valid), .code(next_code), .counts(counts)
  );

  assign cnt_hit   = counts[0];
  assign cnt_comp  = counts[1];
  assign cnt_true  = counts[2];
  assign cnt_false = counts[3];
endmodule

// File: rtl/cmc_checks.sv
module cmc_checks #(
  parameter int NPROC = 2,
  parameter int CW    = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  acc_valid,
  input logic                  cls_valid,
  input logic [1:0]            cls_code,
  input logic [CW-1:0]         cnt_hit,
  input logic [CW-1:0]         cnt_comp,
  input logic [CW-1:0]         cnt_true,
  input logic [CW-1:0]         cnt_false,
  input logic [NPROC-1:0][1:0] cur_st
);
  logic [NPROC-1:0] owner_vec;
  for (genvar q = 0; q < NPROC; q++) begin : g_own
    assign owner_vec[q] = (cur_st[q] == 2'd2);
  end

  // R2
  result_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> cls_valid);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !cls_valid);
  // R10
  single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(owner_vec) <= 1);
  // R9
  hit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_hit) |-> (cls_valid && cls_code == 2'b00));
  // R9
  comp_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_comp) |-> (cls_valid && cls_code == 2'b01));
  // R9
  true_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_true) |-> (cls_valid && cls_code == 2'b10));
  // R9
  false_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_false) |-> (cls_valid && cls_code == 2'b11));
endmodule

bind cmc_classifier cmc_checks #(.NPROC(NPROC), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .cls_valid(cls_valid),
  .cls_code(cls_code), .cnt_hit(cnt_hit), .cnt_comp(cnt_comp),
  .cnt_true(cnt_true), .cnt_false(cnt_false), .cur_st(cur_st)
);

// File: tb/cmc_classifier_test.sv
`timescale 1ns/1ps
module cmc_classifier_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0;
  logic [0:0] acc_pid = '0;
  logic       acc_write = 1'b0;
  logic [1:0] acc_blk = '0;
  logic [1:0] acc_word = '0;
  logic       cls_valid;
  logic [1:0] cls_code;
  logic [15:0] cnt_hit, cnt_comp, cnt_true, cnt_false;

  int errors = 0;
  int checks = 0;
  int exp_cnt [4] = '{0, 0, 0, 0};

  always #5 clk = ~clk;

  cmc_classifier uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_pid(acc_pid),
    .acc_write(acc_write), .acc_blk(acc_blk), .acc_word(acc_word),
    .cls_valid(cls_valid), .cls_code(cls_code), .cnt_hit(cnt_hit),
    .cnt_comp(cnt_comp), .cnt_true(cnt_true), .cnt_false(cnt_false)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // one access, result sampled on the following falling edge
  task automatic access(input int pid, input int wr, input int blk, input int w,
                        input int code, input string tag);
    @(negedge clk);
    acc_valid = 1'b1; acc_pid = 1'(pid); acc_write = wr[0];
    acc_blk = 2'(blk); acc_word = 2'(w);
    @(negedge clk);
    acc_valid = 1'b0;
    check(cls_valid == 1'b1, {tag, " valid"}, int'(cls_valid), 1);
    check(cls_code == 2'(code), tag, int'(cls_code), code);
    if (exp_cnt[code] < 65535) exp_cnt[code]++;
  endtask

  task automatic check_counts(input string tag);
    check(cnt_hit   == 16'(exp_cnt[0]), {tag, " hit count"},   int'(cnt_hit),   exp_cnt[0]);
    check(cnt_comp  == 16'(exp_cnt[1]), {tag, " comp count"},  int'(cnt_comp),  exp_cnt[1]);
    check(cnt_true  == 16'(exp_cnt[2]), {tag, " true count"},  int'(cnt_true),  exp_cnt[2]);
    check(cnt_false == 16'(exp_cnt[3]), {tag, " false count"}, int'(cnt_false), exp_cnt[3]);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(cls_valid == 1'b0, "R1 cls_valid", int'(cls_valid), 0);
    check_counts("R1 reset");
  endtask

  // two words w0/w1 of block 0, processors 0 and 1
  task automatic t_two_word_sharing();
    access(0, 0, 0, 0, 1, "R4 p0 first read");
    access(0, 0, 0, 1, 0, "R3 p0 read hit");
    access(1, 0, 0, 0, 1, "R4 p1 first read");
    access(1, 0, 0, 1, 0, "R3 p1 read hit");
    access(0, 1, 0, 0, 2, "R6 step1 p0 writes w0");
    access(1, 0, 0, 1, 3, "R7 step2 p1 reads w1");
    access(0, 1, 0, 0, 3, "R7 step3 p0 writes w0");
    access(1, 1, 0, 1, 3, "R7 step4 p1 writes w1");
    access(0, 0, 0, 1, 2, "R5 step5 p0 reads w1");
    check_counts("R9 after sequence");
  endtask

  task automatic t_upgrade_demote();
    access(0, 1, 1, 0, 1, "R4 p0 first write");
    access(1, 0, 1, 0, 1, "R4 p1 first read ignores peer");
    access(0, 1, 1, 0, 2, "R8 demoted writer upgrade");
    access(1, 0, 1, 0, 2, "R5 p1 rereads written word");
    access(0, 0, 1, 2, 0, "R8 demoted copy still reads");
    access(0, 1, 1, 2, 3, "R7 upgrade on unused word");
    access(0, 1, 1, 3, 0, "R3 exclusive write hit");
    @(negedge clk);
    check(cls_valid == 1'b0, "R2 idle cycle", int'(cls_valid), 0);
    check_counts("R9 after upgrade");
  endtask

  task automatic t_saturate();
    @(negedge clk);
    acc_valid = 1'b1; acc_pid = 1'b0; acc_write = 1'b0; acc_blk = 2'd1; acc_word = 2'd0;
    repeat (65540) @(negedge clk);
    acc_valid = 1'b0;
    check(cls_code == 2'b00, "R3 repeated read hit", int'(cls_code), 0);
    exp_cnt[0] = 65535;
    check_counts("R9 saturation");
  endtask

  initial begin
    #1_950_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_two_word_sharing();
    t_upgrade_demote();
    t_saturate();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule